// File: doc/BRIEF.md
# Packed Saturating Integer Adder

This block adds or subtracts two 256-bit integer vectors lane by lane. The lanes are 8, 16, 32 or 64 bits wide, chosen per operation. One carry-segmented adder serves every lane width. Around it, a per-lane fix-up stage supplies several results: plain wraparound, signed or unsigned saturation on byte and word lanes, and a rounded unsigned average. A gather stage in front of the adder reorders the operands for horizontal pairwise addition, so the same adder also serves that operation. The block produces no flags.

Operations enter on a valid/ready stream and leave from a single output register on a second valid/ready stream. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or whenever its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is accepted.

A width select picks the operating width. In 256-bit mode the whole vector is computed. In 128-bit mode only the lower half is computed and the upper half of the result is zero.

Top module: `packed_sat_adder`

## Requirements
- R1: The result of an accepted input appears in `out_data` with `out_valid` high on the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` and `out_data` stay unchanged.
- R2: Opcode 0 gives the lane sum and opcode 1 gives A minus B, each kept to the lane width (wraparound). Lane size code 0, 1, 2 and 3 select 8, 16, 32 and 64 bits.
- R3: No carry or borrow crosses a lane boundary at any lane size.
- R4: Opcodes 2 (add) and 3 (subtract) saturate signed: byte lanes clamp to 0x7F or 0x80, and word lanes clamp to 0x7FFF or 0x8000.
- R5: Opcodes 4 (add) and 5 (subtract) saturate unsigned. Overflow gives all ones (0xFF or 0xFFFF) and underflow gives 0.
- R6: Opcode 6 gives the unsigned average (A + B + 1) >> 1 per lane. The intermediate is one bit wider than the lane, and the average works at every lane size.
- R7: Opcode 7 adds adjacent lane pairs, for word and dword lanes. Within each 128-bit half, the low part of the result holds the pair sums of A in order, and the high part holds those of B.
- R8: Opcode 8 works like opcode 7, but word pair sums clamp to the signed word range. With dword lanes it wraps.
- R9: Saturating opcodes 2 to 5 with 32- or 64-bit lanes give the wraparound result.
- R10: With `in_wide` low (128-bit mode), bits 255:128 of the result are zero. With `in_wide` high, all 256 bits are computed.
- R11: Opcodes 9 to 15 give an all-zero result. So do opcodes 7 and 8 with byte or qword lanes.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Block can accept an input |
| in_a | input | 256 | First operand |
| in_b | input | 256 | Second operand |
| in_op | input | 4 | Operation code |
| in_lsz | input | 2 | Lane size code (0..3 = 8..64 bits) |
| in_wide | input | 1 | 1 = 256-bit mode, 0 = 128-bit mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Registered result |

## Verification
The bench builds the block with its default 256-bit vector width. This puts both 128-bit halves within reach, so the bench can check the per-half pair layout of the horizontal add and the zeroing of the upper half in 128-bit mode. All four lane sizes are exercised, including 64-bit lanes, where a carry would have to stop after eight byte segments. Operand bytes are drawn mostly from the boundary values 0x00, 0x7F, 0x80 and 0xFF, so clamps and lane-edge carries occur often. The consumer randomly withholds `out_ready`, which exercises the back-pressure rules.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int SEG_W = 8;

  typedef enum logic [2:0] {
    K_WRAP     = 3'd0,
    K_SSAT     = 3'd1,
    K_USAT_ADD = 3'd2,
    K_USAT_SUB = 3'd3,
    K_AVG      = 3'd4
  } kind_e;

  typedef struct packed {
    logic  inv_y;
    logic  cin;
    logic  pair;
    logic  zero;
    kind_e kind;
  } ctl_t;

  function automatic ctl_t decode(input logic [3:0] op, input logic [1:0] lsz);
    ctl_t c;
    c.inv_y = (op == 4'd1) || (op == 4'd3) || (op == 4'd5);
    c.cin   = c.inv_y || (op == 4'd6);
    c.pair  = (op == 4'd7) || (op == 4'd8);
    c.zero  = (op > 4'd8) || (c.pair && ((lsz == 2'd0) || (lsz == 2'd3)));
    case (op)
      4'd2, 4'd3, 4'd8: c.kind = K_SSAT;
      4'd4:             c.kind = K_USAT_ADD;
      4'd5:             c.kind = K_USAT_SUB;
      4'd6:             c.kind = K_AVG;
      default:          c.kind = K_WRAP;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/psa_hpair.sv
module psa_hpair #(
  parameter int VEC_W = 256,
  parameter int BLK_W = 128
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [1:0]       lsz,
  output logic [VEC_W-1:0] x,
  output logic [VEC_W-1:0] y
);
  localparam int NBLK = VEC_W / BLK_W;

  logic [1:0][VEC_W-1:0] xw;
  logic [1:0][VEC_W-1:0] yw;

  for (genvar h = 0; h < NBLK; h++) begin : g_blk
    for (genvar s = 1; s < 3; s++) begin : g_sz
      localparam int W  = 8 << s;
      localparam int NH = BLK_W / W;
      for (genvar j = 0; j < NH; j++) begin : g_lane
        localparam int  P   = (j < NH / 2) ? j : j - NH / 2;
        localparam int  DST = h * BLK_W + j * W;
        localparam int  SRC = h * BLK_W + 2 * P * W;
        if (j < NH / 2) begin : g_a
          assign xw[s-1][DST +: W] = a[SRC +: W];
          assign yw[s-1][DST +: W] = a[SRC + W +: W];
        end else begin : g_b
          assign xw[s-1][DST +: W] = b[SRC +: W];
          assign yw[s-1][DST +: W] = b[SRC + W +: W];
        end
      end
    end
  end

  assign x = (lsz == 2'd2) ? xw[1] : xw[0];
  assign y = (lsz == 2'd2) ? yw[1] : yw[0];
endmodule

// File: rtl/psa_segadd.sv
module psa_segadd
  import psa_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [VEC_W-1:0]       x,
  input  logic [VEC_W-1:0]       y,
  input  logic                   inv_y,
  input  logic                   cin,
  input  logic [1:0]             lsz,
  output logic [VEC_W-1:0]       sum,
  output logic [VEC_W/SEG_W-1:0] cout
);
  localparam int NSEG = VEC_W / SEG_W;

  logic [2:0] lane_mask;
  assign lane_mask = 3'((4 'd1 << lsz) - 4'd1);

  always_comb begin
    logic             c;
    logic [SEG_W:0]   t;
    logic [SEG_W-1:0] ys;
    c    = cin;
    sum  = '0;
    cout = '0;
    for (int i = 0; i < NSEG; i++) begin
      if ((3'(i) & lane_mask) == 3'd0) c = cin;
      ys = inv_y ? ~y[i*SEG_W +: SEG_W] : y[i*SEG_W +: SEG_W];
      t  = {1'b0, x[i*SEG_W +: SEG_W]} + {1'b0, ys} + {{SEG_W{1'b0}}, c};
      sum[i*SEG_W +: SEG_W] = t[SEG_W-1:0];
      cout[i] = t[SEG_W];
      c = t[SEG_W];
    end
  end
endmodule

// File: rtl/psa_lanefix.sv
module psa_lanefix
  import psa_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [VEC_W-1:0]       x,
  input  logic [VEC_W-1:0]       y,
  input  logic [VEC_W-1:0]       sum,
  input  logic [VEC_W/SEG_W-1:0] cout,
  input  logic                   inv_y,
  input  kind_e                  kind,
  input  logic [1:0]             lsz,
  output logic [VEC_W-1:0]       res
);
  logic [3:0][VEC_W-1:0] per_sz;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W      = 8 << s;
    localparam int NL     = VEC_W / W;
    localparam int SB     = W / SEG_W;
    localparam bit SAT_OK = (W <= 16);
    for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [W-1:0] sl;
      logic [W-1:0] rl;
      logic         xs, ys, ss, co;
      assign sl = sum[k*W +: W];
      assign xs = x[k*W + W - 1];
      assign ys = y[k*W + W - 1] ^ inv_y;
      assign ss = sl[W-1];
      assign co = cout[k*SB + SB - 1];
      always_comb begin
        rl = sl;
        if (kind == K_AVG)
          rl = {co, sl[W-1:1]};
        else if (SAT_OK && (kind == K_SSAT) && (xs == ys) && (ss != xs))
          rl = xs ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else if (SAT_OK && (kind == K_USAT_ADD) && co)
          rl = '1;
        else if (SAT_OK && (kind == K_USAT_SUB) && !co)
          rl = '0;
      end
      assign per_sz[s][k*W +: W] = rl;
    end
  end

  assign res = per_sz[lsz];
endmodule

// File: rtl/packed_sat_adder.sv
module packed_sat_adder
  import psa_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic [3:0]       in_op,
  input  logic [1:0]       in_lsz,
  input  logic             in_wide,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NSEG   = VEC_W / SEG_W;

  ctl_t ctl;
  assign ctl = decode(in_op, in_lsz);

  logic [VEC_W-1:0] hx, hy, opx, opy, sum, fixed;
  logic [VEC_W-1:0] res_n;
  logic [NSEG-1:0]  cout;
  logic             fire;

  psa_hpair #(.VEC_W(VEC_W), .BLK_W(128)) u_hpair (
    .a(in_a), .b(in_b), .lsz(in_lsz), .x(hx), .y(hy)
  );

  assign opx = ctl.pair ? hx : in_a;
  assign opy = ctl.pair ? hy : in_b;

  psa_segadd #(.VEC_W(VEC_W)) u_add (
    .x(opx), .y(opy), .inv_y(ctl.inv_y), .cin(ctl.cin), .lsz(in_lsz),
    .sum(sum), .cout(cout)
  );

  psa_lanefix #(.VEC_W(VEC_W)) u_fix (
    .x(opx), .y(opy), .sum(sum), .cout(cout), .inv_y(ctl.inv_y),
    .kind(ctl.kind), .lsz(in_lsz), .res(fixed)
  );

  always_comb begin
    res_n = ctl.zero ? '0 : fixed;
    if (!in_wide) res_n[VEC_W-1:HALF_W] = '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= res_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_wide |=> out_data[VEC_W-1:HALF_W] == '0);

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd2 && in_lsz == 2'd0 && !in_a[7] && !in_b[7]
    |=> !out_data[7]);

  assert_usub_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd5 && in_lsz == 2'd0 |=> out_data[7:0] <= $past(in_a[7:0]));

  assert_avg_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd6 && in_lsz == 2'd0 |=>
      ((out_data[7:0] >= $past(in_a[7:0])) || (out_data[7:0] >= $past(in_b[7:0]))) &&
      ((out_data[7:0] <= $past(in_a[7:0])) || (out_data[7:0] <= $past(in_b[7:0]))));

  assert_lane_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd0 && in_lsz == 2'd0 |=>
      out_data[15:8] == 8'($past(in_a[15:8]) + $past(in_b[15:8])));

  assert_undef_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op > 4'd8 |=> out_data == '0);
endmodule

// File: tb/sim_packed_sat_adder.sv
`timescale 1ns/1ps
module sim_packed_sat_adder;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_a = '0, in_b = '0;
  logic [3:0]    in_op = '0;
  logic [1:0]    in_lsz = '0;
  logic          in_wide = 1'b1;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [VW-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  packed_sat_adder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_lsz(in_lsz), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] lget(logic [VW-1:0] v, int w, int i);
    logic [VW-1:0] t;
    t = v >> (i * w);
    return (w == 64) ? t[63:0] : (t[63:0] & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic logic [VW-1:0] lput(logic [VW-1:0] v, int w, int i, logic [63:0] d);
    for (int k = 0; k < w; k++) v[i*w + k] = d[k];
    return v;
  endfunction

  function automatic longint sx(logic [63:0] u, int w);
    return u[w-1] ? longint'(u) - (longint'(1) << w) : longint'(u);
  endfunction

  function automatic logic [63:0] sclamp(longint s, int w);
    longint mx, mn;
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -(longint'(1) << (w - 1));
    if (s > mx) s = mx;
    if (s < mn) s = mn;
    return 64'(s);
  endfunction

  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                          logic [3:0] op, logic [1:0] sz, logic wide);
    int w, n, nh;
    bit sat;
    logic [63:0] m, r64;
    logic [64:0] x, y, t;
    logic [VW-1:0] r;
    w = 8 << sz; n = VW / w; nh = 128 / w; sat = (w <= 16);
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    r = '0;
    if (op > 4'd8 || ((op == 4'd7 || op == 4'd8) && (sz == 2'd0 || sz == 2'd3))) return '0;
    if (op == 4'd7 || op == 4'd8) begin
      for (int h = 0; h < VW / 128; h++)
        for (int j = 0; j < nh; j++) begin
          logic [VW-1:0] src;
          int p;
          src = (j < nh / 2) ? a : b;
          p   = (j < nh / 2) ? j : j - nh / 2;
          x = {1'b0, lget(src, w, h*nh + 2*p)};
          y = {1'b0, lget(src, w, h*nh + 2*p + 1)};
          if (op == 4'd8 && sat) r64 = sclamp(sx(x[63:0], w) + sx(y[63:0], w), w);
          else begin t = x + y; r64 = t[63:0]; end
          r = lput(r, w, h*nh + j, r64 & m);
        end
    end else begin
      for (int i = 0; i < n; i++) begin
        x = {1'b0, lget(a, w, i)};
        y = {1'b0, lget(b, w, i)};
        t = x + y;
        if (op == 4'd1 || op == 4'd3 || op == 4'd5) t = x - y;
        r64 = t[63:0];
        if (sat && op == 4'd2) r64 = sclamp(sx(x[63:0], w) + sx(y[63:0], w), w);
        if (sat && op == 4'd3) r64 = sclamp(sx(x[63:0], w) - sx(y[63:0], w), w);
        if (sat && op == 4'd4 && t > {1'b0, m}) r64 = m;
        if (sat && op == 4'd5 && x < y) r64 = '0;
        if (op == 4'd6) begin t = (x + y + 65'd1) >> 1; r64 = t[63:0]; end
        r = lput(r, w, i, r64 & m);
      end
    end
    if (!wide) r[VW-1:128] = '0;
    return r;
  endfunction

  task automatic send(logic [VW-1:0] a, logic [VW-1:0] b, logic [3:0] op,
                      logic [1:0] sz, logic wide, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_op = op; in_lsz = sz; in_wide = wide;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    it.exp = model(a, b, op, sz, wide);
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  function automatic logic [VW-1:0] edgy();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 8; i++) begin
      case ($urandom_range(0, 5))
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'hFF;
        2: v[i*8 +: 8] = 8'h7F;
        3: v[i*8 +: 8] = 8'h80;
        default: v[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  // monitor: pops the scoreboard on every transfer, checks hold under stall
  initial begin
    bit            stalled;
    logic [VW-1:0] held;
    stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        checks++;
        if (!out_valid || out_data !== held) begin
          fails++;
          $display("FAIL R1 hold: valid=%0b data=%h expected %h", out_valid, out_data, held);
        end
      end
      out_ready = ($urandom_range(0, 3) != 0);
      #2;
      if (out_valid && out_ready) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result %h, expected none", out_data);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (out_data !== it.exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", it.tag, out_data, it.exp);
          end
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R12 out_valid=%b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin fails++; $display("FAIL R12 in_ready=%b expected 1", in_ready); end

    send({32{8'hFF}}, {32{8'h01}}, 4'd0, 2'd0, 1'b1, "R2 byte add wrap");
    send({32{8'h03}}, {32{8'h05}}, 4'd1, 2'd0, 1'b1, "R2 byte sub wrap");
    send({16{16'h1234}}, {16{16'hF000}}, 4'd1, 2'd1, 1'b1, "R2 word sub");
    send({4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'd1}}, 4'd0, 2'd3, 1'b1, "R3 qword carry cut");
    send({8{32'hFFFF_FFFF}}, {8{32'd1}}, 4'd0, 2'd2, 1'b1, "R3 dword carry cut");
    send({4{64'd0}}, {4{64'd1}}, 4'd1, 2'd3, 1'b1, "R3 qword borrow cut");
    send({16{8'h7F, 8'h80}}, {16{8'h01, 8'hFF}}, 4'd2, 2'd0, 1'b1, "R4 byte signed add clamp");
    send({16{16'h8000}}, {16{16'h0001}}, 4'd3, 2'd1, 1'b1, "R4 word signed sub clamp");
    send({16{16'h7FFF}}, {16{16'h7FFF}}, 4'd2, 2'd1, 1'b1, "R4 word signed add clamp");
    send({32{8'hF0}}, {32{8'h20}}, 4'd4, 2'd0, 1'b1, "R5 byte unsigned add clamp");
    send({16{16'h0010}}, {16{16'h0020}}, 4'd5, 2'd1, 1'b1, "R5 word unsigned sub floor");
    send({32{8'hFF}}, {32{8'hFF}}, 4'd6, 2'd0, 1'b1, "R6 byte avg max");
    send({32{8'h01}}, {32{8'h02}}, 4'd6, 2'd0, 1'b1, "R6 byte avg round up");
    send({4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'd1}}, 4'd6, 2'd3, 1'b1, "R6 qword avg wide");
    a = '0; b = '0;
    for (int i = 0; i < 16; i++) begin
      a[i*16 +: 16] = 16'(i + 1);
      b[i*16 +: 16] = 16'(16'h100 + i);
    end
    send(a, b, 4'd7, 2'd1, 1'b1, "R7 word hadd layout");
    send(a, b, 4'd7, 2'd2, 1'b1, "R7 dword hadd layout");
    send(a, b, 4'd7, 2'd1, 1'b0, "R7 word hadd narrow");
    send({16{16'h7FFF}}, {16{16'h8000}}, 4'd8, 2'd1, 1'b1, "R8 word hadd clamp");
    send({8{32'h7FFF_FFFF}}, {8{32'h8000_0000}}, 4'd8, 2'd2, 1'b1, "R8 dword hadd wrap");
    send({8{32'h7FFF_FFFF}}, {8{32'd1}}, 4'd2, 2'd2, 1'b1, "R9 dword signed add wraps");
    send({4{64'd0}}, {4{64'd5}}, 4'd5, 2'd3, 1'b1, "R9 qword unsigned sub wraps");
    send({32{8'hAA}}, {32{8'h11}}, 4'd0, 2'd0, 1'b0, "R10 narrow upper zero");
    send({32{8'hAA}}, {32{8'h11}}, 4'd12, 2'd0, 1'b1, "R11 undefined opcode");
    send({32{8'hAA}}, {32{8'h11}}, 4'd7, 2'd0, 1'b1, "R11 hadd byte zero");
    send({32{8'hAA}}, {32{8'h11}}, 4'd8, 2'd3, 1'b1, "R11 hadd qword zero");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] op;
      op = (n % 10 == 9) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      send(edgy(), edgy(), op, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 4) != 0),
           "R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule